// File: doc/BRIEF.md
# Six-Step Complementary PWM Commutation Unit

This block produces three pairs of complementary PWM outputs for a brushless motor bridge run in six-step (trapezoidal) mode. One shared timebase counts down from a programmable reload value to zero and then reloads. Each of the three channels compares the count with its own compare value to form a reference signal. From that reference it drives a high-side pin and a complementary low-side pin. Each pin has its own output-enable, so a pin can be released to high impedance.

Each channel has an output mode, two enables and two polarity bits. Software writes these into a shadow copy. When preloading is switched on, the shadow copies of all three channels move into the active set together, on a single commutation strobe. All six pins therefore change in the same clock cycle, and the bridge never sees a half-written step with a floating or glitching pin. Compare and reload values are also buffered. They take effect at the update event: the counter reaching zero, or a software update strobe.

Top module: `sixstep_pwm`

## Requirements
- R1: While reset is applied and after it is released, all six output-enables are low, all six output values are low, and every channel is in forced-inactive mode.
- R2: When the run bit (control register, address 7, bit 0) is set, the counter decrements once per clock. In the cycle it reads zero, it reloads the buffered reload value (address 0). The period is therefore reload+1 cycles.
- R3: In mode 3'b110, a channel's reference is active while the counter is strictly below the active compare value (addresses 1..3 for channels 0..2), and inactive otherwise.
- R4: Mode 3'b100 holds the reference inactive and mode 3'b101 holds it active. Every other mode code holds it inactive. Mode is config bits [2:0] (addresses 4..6 for channels 0..2).
- R5: The high-side value is the reference XOR the high polarity bit (config bit 5). The low-side value is the inverted reference XOR the low polarity bit (config bit 6). Forced-inactive mode with the low polarity bit set drives both pins low.
- R6: The high-side enable (config bit 3) and the low-side enable (config bit 4) drive the pin output-enables. A disabled pin has its output-enable low and its value low.
- R7: While preload (control bit 1) is set, config writes change no output. Writing control bit 2 copies all three shadow configs to the active set, and all changed pins switch at the clock edge that samples that write.
- R8: While preload is clear, a config write takes effect at the clock edge that samples it.
- R9: A compare write takes effect only at the next update event. Until then, the duty cycle of the current period is unchanged.
- R10: Writing control bit 3 triggers an update at once: the counter restarts from the reload value and the compare values are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| out_hi | output | 3 | High-side pin values, one per channel |
| out_hi_oe | output | 3 | High-side pin output-enables |
| out_lo | output | 3 | Low-side pin values |
| out_lo_oe | output | 3 | Low-side pin output-enables |

## Verification
The bench sweeps the compare value across the full range of a short period, including 0 and values above the reload. An off-by-one comparator or reload would show up as one wrong PWM cycle per period. For every channel it also walks all forced modes together with every combination of polarity and enable. A swapped polarity, or a reversed inversion on the low side, would then drive the wrong pin level or leave the both-low step unreachable. It writes staged configs with preload on and checks that nothing moves until the strobe, and that all channels move together after it; a design that copied too early would leak a partial step. It also writes a compare value mid-period and checks that the old duty cycle survives until the wrap, which catches a compare buffer that is not a real preload.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam logic [2:0] MODE_FORCE_OFF = 3'b100;
  localparam logic [2:0] MODE_FORCE_ON  = 3'b101;
  localparam logic [2:0] MODE_PWM1      = 3'b110;

  typedef struct packed {
    logic       lo_pol;
    logic       hi_pol;
    logic       lo_en;
    logic       hi_en;
    logic [2:0] mode;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
  localparam chan_cfg_t CFG_RESET = '{lo_pol: 1'b0, hi_pol: 1'b0, lo_en: 1'b0,
                                      hi_en: 1'b0, mode: MODE_FORCE_OFF};
endpackage

// File: rtl/sixstep_timebase.sv
module sixstep_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_data,
  input  logic             sw_upd,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;

  assign upd = sw_upd || (run && (cnt_q == '0));
  assign cnt = cnt_q;

  always_comb begin
    rld_d = rld_wr ? rld_data : rld_q;
    cnt_d = cnt_q;
    if (upd)      cnt_d = rld_q;
    else if (run) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  // R2: count down by one while running and not at zero
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sw_upd && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2 / R10: an update loads the buffered reload value
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> cnt_q == $past(rld_q));
endmodule

// File: rtl/sixstep_chan.sv
module sixstep_chan
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             upd,
  input  logic             cmp_wr,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             preload,
  input  logic             comm,
  output logic             hi,
  output logic             hi_oe,
  output logic             lo,
  output logic             lo_oe
);
  logic [CNT_W-1:0] cmp_sh_q, cmp_sh_d, cmp_act_q, cmp_act_d;
  chan_cfg_t        shd_q, shd_d, act_q, act_d;
  logic             ref_sig;

  always_comb begin
    cmp_sh_d  = cmp_wr ? wdata : cmp_sh_q;
    cmp_act_d = upd ? cmp_sh_q : cmp_act_q;
    shd_d     = cfg_wr ? chan_cfg_t'(wdata[CFG_W-1:0]) : shd_q;
    act_d     = act_q;
    if (comm)                   act_d = shd_q;
    else if (cfg_wr && !preload) act_d = chan_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      shd_q     <= CFG_RESET;
      act_q     <= CFG_RESET;
    end else begin
      cmp_sh_q  <= cmp_sh_d;
      cmp_act_q <= cmp_act_d;
      shd_q     <= shd_d;
      act_q     <= act_d;
    end
  end

  always_comb begin
    unique case (act_q.mode)
      MODE_FORCE_ON: ref_sig = 1'b1;
      MODE_PWM1:     ref_sig = (cnt < cmp_act_q);
      default:       ref_sig = 1'b0;
    endcase
  end

  assign hi_oe = act_q.hi_en;
  assign lo_oe = act_q.lo_en;
  assign hi    = act_q.hi_en && (ref_sig ^ act_q.hi_pol);
  assign lo    = act_q.lo_en && (!ref_sig ^ act_q.lo_pol);

  // R7: with preload on, the active set moves only on a commutation strobe
  p_hold_until_comm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !comm) |=> $stable(act_q));
  // R7: the strobe copies the staged config whole
  p_comm_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comm |=> act_q == $past(shd_q));
  // R9: the active compare only changes on an update event
  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cmp_act_q));
endmodule

// File: rtl/sixstep_pwm.sv
module sixstep_pwm
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 3,
  localparam int ADDR_W = $clog2(2 * N_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_CH-1:0]   out_hi,
  output logic [N_CH-1:0]   out_hi_oe,
  output logic [N_CH-1:0]   out_lo,
  output logic [N_CH-1:0]   out_lo_oe
);
  localparam logic [ADDR_W-1:0] A_RELOAD = '0;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2 * N_CH + 1);

  logic             rst_meta, rst_sync;
  logic             run_q, run_d, pre_q, pre_d;
  logic             ctrl_wr, comm, sw_upd, upd;
  logic [CNT_W-1:0] cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign comm    = ctrl_wr && wr_data[2];
  assign sw_upd  = ctrl_wr && wr_data[3];

  always_comb begin
    run_d = ctrl_wr ? wr_data[0] : run_q;
    pre_d = ctrl_wr ? wr_data[1] : pre_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      run_q <= 1'b0;
      pre_q <= 1'b0;
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
    end
  end

  sixstep_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_sync), .run(run_q),
    .rld_wr(wr_en && (wr_addr == A_RELOAD)), .rld_data(wr_data),
    .sw_upd(sw_upd), .cnt(cnt), .upd(upd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    sixstep_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync), .cnt(cnt), .upd(upd),
      .cmp_wr(wr_en && (wr_addr == ADDR_W'(1 + i))),
      .cfg_wr(wr_en && (wr_addr == ADDR_W'(1 + N_CH + i))),
      .wdata(wr_data), .preload(pre_q), .comm(comm),
      .hi(out_hi[i]), .hi_oe(out_hi_oe[i]), .lo(out_lo[i]), .lo_oe(out_lo_oe[i])
    );
  end

  // R6: a released pin never carries a high value
  p_released_low_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    ((out_hi & ~out_hi_oe) == '0) && ((out_lo & ~out_lo_oe) == '0));
  // R1: nothing is enabled during reset
  always_comb begin
    if (!rst_sync) p_reset_quiet_r1: assert ((out_hi_oe | out_lo_oe) == '0);
  end
endmodule

// File: tb/sixstep_pwm_bench.sv
module sixstep_pwm_bench;
  localparam int R = 5;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  out_hi, out_hi_oe, out_lo, out_lo_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sixstep_pwm u_sixstep_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_hi(out_hi), .out_hi_oe(out_hi_oe), .out_lo(out_lo), .out_lo_oe(out_lo_oe)
  );

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {hi, hi_oe, lo, lo_oe} for one channel
  function automatic logic [3:0] pin_exp(input logic [6:0] cfg, input logic pwm_ref);
    logic r, h, l;
    r = (cfg[2:0] == 3'b101) ? 1'b1 : (cfg[2:0] == 3'b110) ? pwm_ref : 1'b0;
    h = cfg[3] & (r ^ cfg[5]);
    l = cfg[4] & (~r ^ cfg[6]);
    return {h, cfg[3], l, cfg[4]};
  endfunction

  function automatic logic [11:0] all_exp(input logic [6:0] c0, input logic [6:0] c1,
                                          input logic [6:0] c2);
    logic [3:0] e0, e1, e2;
    e0 = pin_exp(c0, 1'b0); e1 = pin_exp(c1, 1'b0); e2 = pin_exp(c2, 1'b0);
    return {e2[3], e1[3], e0[3], e2[2], e1[2], e0[2],
            e2[1], e1[1], e0[1], e2[0], e1[0], e0[0]};
  endfunction

  function automatic logic [11:0] pins();
    return {out_hi, out_hi_oe, out_lo, out_lo_oe};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pins(), 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", pins(), 12'h000);

    // R4 R5 R6 R8: forced modes, polarities, enables, preload off
    wr(3'd7, 16'h0000);
    for (int ch = 0; ch < 3; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int b = 0; b < 16; b++) begin
          logic [6:0] cfg;
          logic [3:0] e;
          cfg = {b[3:0], (m == 0) ? 3'b100 : (m == 1) ? 3'b101 : (m == 2) ? 3'b111 : 3'b000};
          wr(3'(4 + ch), 16'(cfg));
          e = pin_exp(cfg, 1'b0);
          chk("R4 R5 R6 R8 forced", {out_hi[ch], out_hi_oe[ch], out_lo[ch], out_lo_oe[ch]}, {8'h0, e});
        end
      end
      wr(3'(4 + ch), 16'h0004);
    end
    // R5: forced-inactive with low polarity gives both pins driven low
    wr(3'd4, 16'h005C);
    chk("R5 both low", {out_hi[0], out_hi_oe[0], out_lo[0], out_lo_oe[0]}, 12'h5);

    // R2 R3 R10: compare sweep, mode PWM1 on channel 0
    wr(3'd0, 16'(R));
    wr(3'd4, 16'h001E);
    for (int c = 0; c <= R + 2; c++) begin
      wr(3'd1, 16'(c));
      wr(3'd7, 16'h0009);
      for (int k = 0; k < 2 * (R + 1) + 1; k++) begin
        int cnt_e;
        logic r;
        cnt_e = R - (k % (R + 1));
        r = (cnt_e < c);
        chk("R2 R3 R10 pwm", {10'h0, out_hi[0], out_lo[0]}, {10'h0, r, ~r});
        @(negedge clk);
      end
    end

    // R9: compare written mid-period waits for the wrap
    wr(3'd1, 16'd2);
    wr(3'd7, 16'h0009);
    wr(3'd1, 16'd4);
    for (int k = 1; k < 3 * (R + 1); k++) begin
      int cnt_e, c_e;
      logic r;
      cnt_e = R - (k % (R + 1));
      c_e = (k / (R + 1) == 0) ? 2 : 4;
      r = (cnt_e < c_e);
      chk("R9 compare preload", {11'h0, out_hi[0]}, {11'h0, r});
      @(negedge clk);
    end

    // R7: staged configs switch together on the strobe
    wr(3'd7, 16'h0000);
    wr(3'd4, 16'h001C); wr(3'd5, 16'h001C); wr(3'd6, 16'h001C);
    chk("R8 direct base", pins(), all_exp(7'h1C, 7'h1C, 7'h1C));
    wr(3'd7, 16'h0002);
    wr(3'd4, 16'h001D);
    chk("R7 hold ch0", pins(), all_exp(7'h1C, 7'h1C, 7'h1C));
    wr(3'd5, 16'h005C);
    chk("R7 hold ch1", pins(), all_exp(7'h1C, 7'h1C, 7'h1C));
    wr(3'd6, 16'h0004);
    chk("R7 hold ch2", pins(), all_exp(7'h1C, 7'h1C, 7'h1C));
    @(negedge clk);
    chk("R7 still held", pins(), all_exp(7'h1C, 7'h1C, 7'h1C));
    wr(3'd7, 16'h0006);
    chk("R7 commutate", pins(), all_exp(7'h1D, 7'h5C, 7'h04));
    wr(3'd7, 16'h0002);
    chk("R7 strobe not sticky", pins(), all_exp(7'h1D, 7'h5C, 7'h04));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule